// File: doc/BRIEF.md
# Nibble-Serial Result Transmitter

This block is the last stage of a small arithmetic pipeline. It takes an 11-bit result word from the stage upstream through a valid/ready handshake: a 10-bit value plus a carry flag. It then returns the word to an external host four bits at a time. The host drives a serial clock pin and a read-enable pin. Both pins are asynchronous to the block clock and are synchronized inside the block. Each rising serial-clock edge seen while read-enable is high consumes the nibble now on the output bus and presents the next one. Nibbles go out least-significant first.

The word travels as three nibbles, with the carry in payload bit 10 and the top bit zero-padded. A separate status pin is high while an unread word is held. The block accepts a new word only when it holds none. A host that stops reading therefore stalls the pipeline behind it, and no result is lost.

Top module: `nibble_result_tx`

## Requirements
- R1: After reset, `res_ready` is 1, `avail_out` is 0 and `nib_out` is 0.
- R2: When `res_valid` and `res_ready` are both high at a clock edge, the next cycle shows `avail_out`=1 and `res_ready`=0. `nib_out` then shows payload bits [3:0], where the payload is {carry, data} with the carry in bit 10.
- R3: While a word is held, changes on `res_valid`, `res_data` and `res_carry` are ignored: `nib_out` and `res_ready` do not change.
- R4: Successive qualified serial-clock rising edges present payload bits [7:4] and then {0, payload[10:8]}, one nibble per edge.
- R5: A serial-clock rising edge while read-enable is low does not advance the nibble.
- R6: A serial clock held high, with read-enable high, advances exactly one nibble. Its falling edge advances nothing.
- R7: The third qualified edge releases the word: the next cycle shows `avail_out`=0, `res_ready`=1 and `nib_out`=0.
- R8: With the default two synchronizer stages, `nib_out` changes on the third block-clock edge after the serial clock pin rises, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_data | input | 10 | Result value from upstream |
| res_carry | input | 1 | Carry flag from upstream |
| res_valid | input | 1 | Upstream word is valid |
| res_ready | output | 1 | Block can take a word |
| sclk_pin | input | 1 | Host serial clock (asynchronous) |
| rden_pin | input | 1 | Host read enable (asynchronous) |
| nib_out | output | 4 | Current result nibble |
| avail_out | output | 1 | Unread word held |

## Verification
A handshake is taken one cycle after the edge on which valid and ready are both high. The bench samples the status, ready and first nibble on the falling edge that follows. A serial-clock rise moves the nibble three block-clock edges after the pin changes: two synchronizer flops, then the register update. The bench therefore waits four cycles before each nibble check. For the latency requirement it samples once after two edges, where the nibble must be unchanged, and once after the third. All samples are taken on falling clock edges, away from the edge where the design updates.

// File: rtl/nibble_result_tx.sv
module nibble_result_tx #(
  parameter int RES_W       = 10,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_carry,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic             sclk_pin,
  input  logic             rden_pin,
  output logic [NIB_W-1:0] nib_out,
  output logic             avail_out
);
  localparam int PAY_W   = RES_W + 1;
  localparam int NIB_CNT = (PAY_W + NIB_W - 1) / NIB_W;
  localparam int SH_W    = NIB_CNT * NIB_W;
  localparam int CNT_W   = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1;

  logic [SYNC_STAGES-1:0] sclk_sy, rden_sy;
  logic                   sclk_d;
  logic                   held;
  logic [SH_W-1:0]        sh;
  logic [CNT_W-1:0]       cnt;

  wire sclk_s = sclk_sy[SYNC_STAGES-1];
  wire rden_s = rden_sy[SYNC_STAGES-1];
  wire adv    = held && rden_s && sclk_s && !sclk_d;
  wire last   = (cnt == CNT_W'(NIB_CNT - 1));
  wire take   = res_valid && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      rden_sy <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy[0] <= sclk_pin;
      rden_sy[0] <= rden_pin;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclk_sy[i] <= sclk_sy[i-1];
        rden_sy[i] <= rden_sy[i-1];
      end
      sclk_d <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      sh   <= '0;
      cnt  <= '0;
    end else if (take) begin
      held <= 1'b1;
      sh   <= SH_W'({res_carry, res_data});
      cnt  <= '0;
    end else if (adv) begin
      sh  <= sh >> NIB_W;
      cnt <= cnt + 1'b1;
      if (last) held <= 1'b0;
    end
  end

  assign res_ready = !held;
  assign avail_out = held;
  assign nib_out   = held ? sh[NIB_W-1:0] : '0;
endmodule

// File: rtl/nibble_result_tx_chk.sv
module nibble_result_tx_chk #(
  parameter int NIB_W = 4,
  parameter int CNT_W = 2,
  parameter int LAST  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic             avail_out,
  input logic [NIB_W-1:0] nib_out,
  input logic             adv,
  input logic [CNT_W-1:0] cnt
);
  // R2
  accept_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (avail_out && !res_ready));

  // R3
  idle_nibble_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_out && !adv) |=> $stable(nib_out));

  // R3
  idle_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_out && !adv) |=> (avail_out && !res_ready));

  // R4
  early_step_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt != CNT_W'(LAST)) |=> avail_out);

  // R7
  final_step_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == CNT_W'(LAST)) |=> (res_ready && !avail_out && nib_out == '0));
endmodule

bind nibble_result_tx nibble_result_tx_chk #(
  .NIB_W(NIB_W), .CNT_W(CNT_W), .LAST(NIB_CNT - 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .avail_out(avail_out), .nib_out(nib_out), .adv(adv), .cnt(cnt)
);

// File: tb/sim_nibble_result_tx.sv
module sim_nibble_result_tx;
  logic clk = 0, rst_n = 0;
  logic [9:0] res_data = '0;
  logic res_carry = 0, res_valid = 0, sclk_pin = 0, rden_pin = 0;
  logic res_ready, avail_out;
  logic [3:0] nib_out;
  int checks = 0, failures = 0;

  nibble_result_tx u0 (.clk(clk), .rst_n(rst_n), .res_data(res_data), .res_carry(res_carry),
    .res_valid(res_valid), .res_ready(res_ready), .sclk_pin(sclk_pin), .rden_pin(rden_pin),
    .nib_out(nib_out), .avail_out(avail_out));

  always #5 clk = ~clk;

  localparam logic [10:0] VEC [5] = '{11'h7FF, 11'h41A, 11'h3A5, 11'h5C3, 11'h001};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [10:0] w);
    @(negedge clk);
    res_data = w[9:0]; res_carry = w[10]; res_valid = 1;
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic pulse(input logic rd);
    rden_pin = rd;
    repeat (3) @(negedge clk);
    sclk_pin = 1;
    repeat (4) @(negedge clk);
    sclk_pin = 0;
    repeat (4) @(negedge clk);
    rden_pin = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ready", res_ready, 1);
    chk("R1 avail", avail_out, 0);
    chk("R1 nib", nib_out, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      load(VEC[v]);
      chk("R2 avail", avail_out, 1);
      chk("R2 ready", res_ready, 0);
      chk("R2 nib0", nib_out, int'(VEC[v][3:0]));
      pulse(1);
      chk("R4 nib1", nib_out, int'(VEC[v][7:4]));
      pulse(1);
      chk("R4 nib2", nib_out, int'({1'b0, VEC[v][10:8]}));
      pulse(1);
      chk("R7 avail", avail_out, 0);
      chk("R7 ready", res_ready, 1);
      chk("R7 nib", nib_out, 0);
    end

    load(11'h2B6);
    // R3: new words offered while one is held are ignored
    res_data = 10'h3C9; res_carry = 1; res_valid = 1;
    repeat (5) @(negedge clk);
    chk("R3 nib", nib_out, 4'h6);
    chk("R3 ready", res_ready, 0);
    res_valid = 0;
    // R5
    pulse(0);
    chk("R5 nib", nib_out, 4'h6);
    chk("R5 avail", avail_out, 1);
    // R8 latency and R6 held-high clock
    rden_pin = 1;
    repeat (3) @(negedge clk);
    sclk_pin = 1;
    repeat (2) @(negedge clk);
    chk("R8 before", nib_out, 4'h6);
    @(negedge clk);
    chk("R8 after", nib_out, 4'hB);
    repeat (10) @(negedge clk);
    chk("R6 held high", nib_out, 4'hB);
    sclk_pin = 0;
    repeat (6) @(negedge clk);
    chk("R6 fall", nib_out, 4'hB);
    rden_pin = 0;
    repeat (3) @(negedge clk);
    pulse(1);
    chk("R4 top", nib_out, 4'h2);
    pulse(1);
    chk("R7 drained", avail_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule